// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block owns the SDRAM command and address pins from reset until the memory is ready for ordinary traffic. After a synchronous active-low reset it holds the bus at NOP for a programmable stabilization interval. It then closes every bank with a single precharge, issues a fixed number of auto-refresh commands, and loads the mode register with a word built from parameters. Once the last mandatory gap has elapsed it raises a ready flag, and a downstream command controller takes over the pins from that cycle on.

All intervals are whole clock cycles and are set by parameters. At a 100 MHz clock the default stabilization count of 20000 cycles gives the required 200 µs. A state machine with eight named states walks the script. POWER_WAIT counts down the stabilization interval and moves to PRECHARGE when the count expires. PRECHARGE goes to PRE_GAP, or straight to REFRESH when the precharge interval is one cycle. PRE_GAP moves to REFRESH on expiry. REFRESH goes to REF_GAP, or straight to the next REFRESH or to LOAD_MODE when the refresh interval is one cycle. REF_GAP returns to REFRESH, or moves to LOAD_MODE once every refresh has been issued. LOAD_MODE goes to MODE_GAP, or straight to READY when the mode interval is one cycle. MODE_GAP moves to READY on expiry. READY holds until the next reset. A single shared down-counter times every wait, and a small counter tracks the refreshes issued.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111) with bank and address zero and `init_done` low. Asserting reset at any point, even mid-sequence, restarts the whole script from the stabilization wait.
- R2: After reset is released only NOP is driven until the precharge appears, which happens in the cycle that begins at the WAIT_CYCLES-th rising edge after release.
- R3: Exactly one precharge is issued, encoded 0010, with address bit PRE_ALL_BIT (bit 10 by default) high to select all banks, and all other address bits and the bank select zero.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued, each encoded 0001, with address and bank zero. All of them follow the precharge.
- R5: The first refresh appears T_RP rising edges after the precharge.
- R6: Each later refresh appears T_RFC edges after the previous refresh, and the mode load appears T_RFC edges after the last refresh.
- R7: The mode load is encoded 0000 with bank zero and address word: burst length in bits [2:0], burst type in bit 3, CAS latency in bits [6:4], write-burst mode in bit 9, and all other bits zero. It comes only after all the refreshes.
- R8: `init_done` rises T_MRD edges after the mode load, then stays high with NOP on the pins until the next reset.
- R9: Each command lasts exactly one cycle, only the four encodings NOP, precharge, refresh and mode load ever appear, and an interval of one cycle produces back-to-back commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every interval is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset, restarts the script |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address bus, which carries the all-bank bit and the mode word |
| init_done | output | 1 | High once the start-up script is complete |

## Verification
The main instance is built with a 40-cycle stabilization wait, T_RP = 3, T_RFC = 5 and T_MRD = 2. These distinct gaps make every interval visible in a short trace. Its mode parameters set every mode field, including burst type and write-burst mode, to non-default values, so any misplaced bit changes the word on the address pins. A second instance uses a one-cycle wait, intervals of one cycle and only two refreshes. That reaches the paths that skip the gap states and produces back-to-back commands. Resets applied during the refresh phase and after completion check that the script restarts from the wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_POWER_WAIT,
        ST_PRECHARGE,
        ST_PRE_GAP,
        ST_REFRESH,
        ST_REF_GAP,
        ST_LOAD_MODE,
        ST_MODE_GAP,
        ST_READY
    } init_state_e;

    // Command codes as {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP       = 4'b0111;
    localparam logic [3:0] CMD_PRECHARGE = 4'b0010;
    localparam logic [3:0] CMD_REFRESH   = 4'b0001;
    localparam logic [3:0] CMD_LOAD_MODE = 4'b0000;

    function automatic logic [15:0] build_mode_word(
        input logic [2:0] burst_len,
        input logic       burst_type,
        input logic [2:0] cas_lat,
        input logic       write_single
    );
        logic [15:0] word;
        word      = '0;
        word[2:0] = burst_len;
        word[3]   = burst_type;
        word[6:4] = cas_lat;
        word[9]   = write_single;
        return word;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter: reset loads the power-up wait, later loads set the gaps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_ref_counter.sv
module sdram_init_ref_counter #(
    parameter int TOTAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    output logic final_pending,
    output logic all_issued
);

    localparam int CW = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bump && (cnt_q != CW'(TOTAL))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // final_pending: the refresh now on the bus is the last one
    assign final_pending = (cnt_q == CW'(TOTAL - 1));
    assign all_issued    = (cnt_q == CW'(TOTAL));

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int          ADDR_W      = 13,
    parameter int          BA_W        = 2,
    parameter int          PRE_ALL_BIT = 10,
    parameter logic [15:0] MODE_WORD   = 16'h0000
) (
    input  init_state_e        state,
    output logic [3:0]         cmd,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr,
    output logic               done
);

    // Output process: pins are decoded from the state register only
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        done = 1'b0;
        unique case (state)
            ST_PRECHARGE: begin
                cmd               = CMD_PRECHARGE;
                addr[PRE_ALL_BIT] = 1'b1;
            end
            ST_REFRESH: begin
                cmd = CMD_REFRESH;
            end
            ST_LOAD_MODE: begin
                cmd  = CMD_LOAD_MODE;
                addr = ADDR_W'(MODE_WORD);
            end
            ST_READY: begin
                done = 1'b1;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int         WAIT_CYCLES       = 20000,
    parameter int         T_RP              = 2,
    parameter int         T_RFC             = 7,
    parameter int         T_MRD             = 2,
    parameter int         REFRESH_COUNT     = 8,
    parameter int         ADDR_W            = 13,
    parameter int         BA_W              = 2,
    parameter int         PRE_ALL_BIT       = 10,
    parameter logic [2:0] MODE_BURST_LEN    = 3'b011,
    parameter logic       MODE_BURST_TYPE   = 1'b0,
    parameter logic [2:0] MODE_CAS_LAT      = 3'b010,
    parameter logic       MODE_WRITE_SINGLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    localparam int MAX_A        = (WAIT_CYCLES > T_RFC) ? WAIT_CYCLES : T_RFC;
    localparam int MAX_B        = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_INTERVAL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W        = $clog2(MAX_INTERVAL + 1);

    // A gap state lasts interval-1 cycles; an interval of 1 skips it
    localparam bit RP_SKIP  = (T_RP  <= 1);
    localparam bit RFC_SKIP = (T_RFC <= 1);
    localparam bit MRD_SKIP = (T_MRD <= 1);
    localparam logic [TMR_W-1:0] RP_LOAD  = TMR_W'((T_RP  > 1) ? T_RP  - 2 : 0);
    localparam logic [TMR_W-1:0] RFC_LOAD = TMR_W'((T_RFC > 1) ? T_RFC - 2 : 0);
    localparam logic [TMR_W-1:0] MRD_LOAD = TMR_W'((T_MRD > 1) ? T_MRD - 2 : 0);
    localparam int WAIT_RST = (WAIT_CYCLES > 0) ? WAIT_CYCLES - 1 : 0;

    localparam logic [15:0] MODE_WORD = build_mode_word(MODE_BURST_LEN, MODE_BURST_TYPE,
                                                        MODE_CAS_LAT, MODE_WRITE_SINGLE);

    init_state_e      state_q, state_d;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             ref_bump;
    logic             ref_final;
    logic             ref_all;
    logic [3:0]       cmd;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_POWER_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and the control strobes for the timer and refresh counter
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_bump = 1'b0;
        unique case (state_q)
            ST_POWER_WAIT: begin
                if (tmr_expired) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                if (RP_SKIP) begin
                    state_d = ST_REFRESH;
                end else begin
                    state_d  = ST_PRE_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = RP_LOAD;
                end
            end
            ST_PRE_GAP: begin
                if (tmr_expired) state_d = ST_REFRESH;
            end
            ST_REFRESH: begin
                ref_bump = 1'b1;
                if (RFC_SKIP) begin
                    state_d = ref_final ? ST_LOAD_MODE : ST_REFRESH;
                end else begin
                    state_d  = ST_REF_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = RFC_LOAD;
                end
            end
            ST_REF_GAP: begin
                if (tmr_expired) state_d = ref_all ? ST_LOAD_MODE : ST_REFRESH;
            end
            ST_LOAD_MODE: begin
                if (MRD_SKIP) begin
                    state_d = ST_READY;
                end else begin
                    state_d  = ST_MODE_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = MRD_LOAD;
                end
            end
            ST_MODE_GAP: begin
                if (tmr_expired) state_d = ST_READY;
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                state_d = ST_POWER_WAIT;
            end
        endcase
    end

    sdram_init_timer #(
        .CNT_W   (TMR_W),
        .RST_VAL (WAIT_RST)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_init_ref_counter #(
        .TOTAL (REFRESH_COUNT)
    ) u_ref_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .bump          (ref_bump),
        .final_pending (ref_final),
        .all_issued    (ref_all)
    );

    sdram_init_cmd_enc #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .PRE_ALL_BIT (PRE_ALL_BIT),
        .MODE_WORD   (MODE_WORD)
    ) u_cmd_enc (
        .state (state_q),
        .cmd   (cmd),
        .ba    (sd_ba),
        .addr  (sd_addr),
        .done  (init_done)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
    import sdram_init_pkg::*;
#(
    parameter int WAIT_CYCLES   = 20000,
    parameter int REFRESH_COUNT = 8,
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2,
    parameter int PRE_ALL_BIT   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);

    localparam int CYC_W = $clog2(WAIT_CYCLES + 2);
    localparam int REF_W = $clog2(REFRESH_COUNT + 2);

    logic [3:0]       cmd;
    logic [CYC_W-1:0] cyc_q;
    logic [REF_W-1:0] refs_q;
    logic             pre_seen_q;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Edges since reset release, saturating just past the wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != CYC_W'(WAIT_CYCLES + 1)) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Commands observed so far on the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs_q     <= '0;
            pre_seen_q <= 1'b0;
        end else begin
            if (cmd == CMD_REFRESH && refs_q != REF_W'(REFRESH_COUNT + 1)) refs_q <= refs_q + 1'b1;
            if (cmd == CMD_PRECHARGE) pre_seen_q <= 1'b1;
        end
    end

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < CYC_W'(WAIT_CYCLES)) |-> (cmd == CMD_NOP)); // R2
    AST_FIRST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_W'(WAIT_CYCLES)) |-> (cmd == CMD_PRECHARGE)); // R2
    AST_PRECHARGE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRECHARGE) |-> sd_addr[PRE_ALL_BIT]); // R3
    AST_PRECHARGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRECHARGE) |-> !pre_seen_q); // R3
    AST_REFRESH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REFRESH) |-> (pre_seen_q && refs_q < REF_W'(REFRESH_COUNT))); // R4
    AST_MODE_AFTER_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD_MODE) |-> (refs_q == REF_W'(REFRESH_COUNT) && sd_ba == '0)); // R7
    AST_DONE_AFTER_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (refs_q == REF_W'(REFRESH_COUNT))); // R8
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP)); // R8
    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd == CMD_PRECHARGE || cmd == CMD_REFRESH
         || cmd == CMD_LOAD_MODE)); // R9

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .WAIT_CYCLES   (WAIT_CYCLES),
    .REFRESH_COUNT (REFRESH_COUNT),
    .ADDR_W        (ADDR_W),
    .BA_W          (BA_W),
    .PRE_ALL_BIT   (PRE_ALL_BIT)
) u_init_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .init_done (init_done)
);

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] PRE  = 4'b0010;
    localparam logic [3:0] REF  = 4'b0001;
    localparam logic [3:0] LMR  = 4'b0000;

    localparam int WAIT_A = 40;
    localparam int N_STEP = 11;

    // Expected trace for the main instance: gap in edges since the previous event
    localparam logic [3:0]  STEP_CMD  [N_STEP] = '{PRE, REF, REF, REF, REF, REF, REF, REF, REF, LMR, NOP};
    localparam int          STEP_GAP  [N_STEP] = '{WAIT_A, 3, 5, 5, 5, 5, 5, 5, 5, 5, 2};
    localparam logic [12:0] STEP_ADDR [N_STEP] = '{13'h400, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0,
                                                  13'h0, 13'h0, 13'h0, 13'h23A, 13'h0};
    localparam logic        STEP_DONE [N_STEP] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                                  1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    // Requirement per step: R2 precharge time, R5 first refresh, R6 refresh spacing, R8 done
    localparam int          STEP_REQ  [N_STEP] = '{2, 5, 6, 6, 6, 6, 6, 6, 6, 6, 8};

    logic clk = 1'b0;
    logic rst_a_n = 1'b0;
    logic rst_b_n = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;

    logic        cs_a, ras_a, cas_a, we_a, done_a;
    logic [1:0]  ba_a;
    logic [12:0] addr_a;
    logic        cs_b, ras_b, cas_b, we_b, done_b;
    logic [1:0]  ba_b;
    logic [12:0] addr_b;
    logic [3:0]  cmd_a, cmd_b;

    assign cmd_a = {cs_a, ras_a, cas_a, we_a};
    assign cmd_b = {cs_b, ras_b, cas_b, we_b};

    always #2 clk = ~clk;

    sdram_init_seq #(
        .WAIT_CYCLES (WAIT_A), .T_RP (3), .T_RFC (5), .T_MRD (2), .REFRESH_COUNT (8),
        .MODE_BURST_LEN (3'b010), .MODE_BURST_TYPE (1'b1),
        .MODE_CAS_LAT (3'b011), .MODE_WRITE_SINGLE (1'b1)
    ) i_sdram_init_seq (
        .clk (clk), .rst_n (rst_a_n),
        .sd_cs_n (cs_a), .sd_ras_n (ras_a), .sd_cas_n (cas_a), .sd_we_n (we_a),
        .sd_ba (ba_a), .sd_addr (addr_a), .init_done (done_a)
    );

    sdram_init_seq #(
        .WAIT_CYCLES (1), .T_RP (1), .T_RFC (1), .T_MRD (1), .REFRESH_COUNT (2)
    ) i_sdram_init_seq_fast (
        .clk (clk), .rst_n (rst_b_n),
        .sd_cs_n (cs_b), .sd_ras_n (ras_b), .sd_cas_n (cas_b), .sd_we_n (we_b),
        .sd_ba (ba_b), .sd_addr (addr_b), .init_done (done_b)
    );

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Walk the expected trace of the main instance from a reset release at a negedge
    task automatic walk_trace_a();
        for (int i = 0; i < N_STEP; i++) begin
            bit quiet = 1'b1;
            logic [31:0] bad = '0;
            for (int j = 1; j < STEP_GAP[i]; j++) begin
                @(negedge clk);
                if (cmd_a != NOP || done_a || addr_a != '0 || ba_a != '0) begin
                    quiet = 1'b0;
                    bad   = {done_a, ba_a, addr_a, cmd_a};
                end
            end
            // R9: only NOP between commands
            check(quiet, (i == 0) ? 2 : 9, $sformatf("quiet gap before step %0d", i),
                  bad, {1'b0, 2'b00, 13'h0, NOP});
            @(negedge clk);
            check(cmd_a == STEP_CMD[i] && addr_a == STEP_ADDR[i] && ba_a == '0
                  && done_a == STEP_DONE[i], STEP_REQ[i], $sformatf("event step %0d", i),
                  {done_a, ba_a, addr_a, cmd_a}, {STEP_DONE[i], 2'b00, STEP_ADDR[i], STEP_CMD[i]});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of both instances
        check(cmd_a == NOP && !done_a && addr_a == '0 && ba_a == '0, 1, "reset state A",
              {done_a, ba_a, addr_a, cmd_a}, {1'b0, 2'b00, 13'h0, NOP});
        check(cmd_b == NOP && !done_b && addr_b == '0 && ba_b == '0, 1, "reset state B",
              {done_b, ba_b, addr_b, cmd_b}, {1'b0, 2'b00, 13'h0, NOP});

        // R2 R3 R4 R5 R6 R7 R8: full script on the main instance
        rst_a_n = 1'b1;
        walk_trace_a();

        // R8: done stays high with the bus quiet
        begin
            bit held = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!done_a || cmd_a != NOP) held = 1'b0;
            end
            check(held, 8, "done held and bus quiet", {31'h0, held}, 32'h1);
        end

        // R1: reset after completion clears done
        rst_a_n = 1'b0;
        @(negedge clk);
        check(!done_a && cmd_a == NOP, 1, "reset after done", {done_a, cmd_a}, {1'b0, NOP});
        rst_a_n = 1'b1;

        // R1: reset in the middle of the refresh phase, then a full restart
        repeat (WAIT_A + 3 + 10) @(negedge clk);
        rst_a_n = 1'b0;
        @(negedge clk);
        check(!done_a && cmd_a == NOP && addr_a == '0, 1, "reset mid refresh",
              {done_a, addr_a, cmd_a}, {1'b0, 13'h0, NOP});
        rst_a_n = 1'b1;
        walk_trace_a();

        // R9: one-cycle intervals give back-to-back commands on the fast instance
        rst_b_n = 1'b1;
        @(negedge clk);
        check(cmd_b == PRE && addr_b == 13'h400 && ba_b == '0, 2, "fast precharge after one edge",
              {ba_b, addr_b, cmd_b}, {2'b00, 13'h400, PRE});
        @(negedge clk);
        check(cmd_b == REF && addr_b == '0, 5, "fast first refresh", {addr_b, cmd_b}, {13'h0, REF});
        @(negedge clk);
        check(cmd_b == REF && addr_b == '0, 6, "fast second refresh", {addr_b, cmd_b}, {13'h0, REF});
        @(negedge clk);
        // R7: default mode word BL=011, type 0, CL=010, write-burst 0 -> 0x023
        check(cmd_b == LMR && addr_b == 13'h023 && ba_b == '0, 7, "fast mode load",
              {ba_b, addr_b, cmd_b}, {2'b00, 13'h023, LMR});
        @(negedge clk);
        check(done_b && cmd_b == NOP, 8, "fast done", {done_b, cmd_b}, {1'b1, NOP});
        @(negedge clk);
        check(done_b && cmd_b == NOP, 4, "fast no extra refresh", {done_b, cmd_b}, {1'b1, NOP});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule